// File: doc/BRIEF.md
# Address Translation Buffer with Two-Level Table Walker

This block turns virtual addresses into physical addresses. An eight-entry, fully associative array holds recent translations. A request that matches a valid entry gets its answer in the next cycle. A request that misses starts a built-in walker. The walker reads a two-level page table from untranslated physical memory through a simple read port, then installs the leaf entry into the array and answers the request.

Each answer carries one of three outcomes: a physical address, a page fault, or a protection fault. A page fault means some table level was marked not present. A protection fault means the access type is not allowed by the entry's permission bits. While a walk is in progress, the request side holds off with a ready/valid handshake. A flush input clears every entry at once.

The table base comes from a page-table base input. The page offset always passes through unchanged.

Top module: `tlb_ptw`

## Requirements
- R1: The physical address is the entry's 20-bit physical page number in bits 31:12, joined to the request's bits 11:0, which pass through unchanged.
- R2: A request that matches a valid entry is answered with rsp_valid_o high in the cycle after it is accepted. It makes no memory read, and req_ready_o stays high.
- R3: A miss makes two memory reads. The first reads (ptbr_i[31:12] << 12) + 4*va[31:22]. The second reads (first-level word[31:12] << 12) + 4*va[21:12]. In a table word, bit 0 is present, bit 1 readable, bit 2 writable, bit 3 dirty, and bits 31:12 hold the page number. The result is installed, so a later access to the same page hits.
- R4: The same virtual page never matches more than one entry.
- R5: If either level's word has bit 0 clear, the answer is a page fault (rsp_fault_o = 1) with address 0, and nothing is installed. A first-level fault ends the walk after one read. A retry walks again.
- R6: A read needs the readable bit and a write needs the writable bit. A denied access answers with a protection fault (rsp_fault_o = 2) and address 0. A permitted access answers with rsp_fault_o = 0. A leaf that fails this check is still installed.
- R7: Installs go to the eight slots in turn. The ninth distinct page evicts the oldest of eight, and the other seven still hit.
- R8: A permitted write sets the entry's dirty bit, whether it hits a clean entry or is installed by a walk. rsp_dirty_o reports the entry's dirty bit after the access. A denied write leaves the bit unchanged.
- R9: flush_i invalidates every entry in one cycle and holds req_ready_o low during that cycle. Afterwards, previously cached pages walk again.
- R10: From the acceptance of a missing request until its answer, req_ready_o stays low. A memory request holds its valid and address until mem_req_ready_i is seen.
- R11: During reset, req_ready_o is high and rsp_valid_o and mem_req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ptbr_i | input | 32 | Physical address of the first-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_va_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| rsp_valid_o | output | 1 | Answer valid (one cycle) |
| rsp_pa_o | output | 32 | Physical address, 0 on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_dirty_o | output | 1 | Dirty bit of the entry after the access |
| mem_req_valid_o | output | 1 | Table read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Table word address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Table word |

## Verification
The block is driven with repeated accesses to one page, and answer latency and memory-read counts separate hits from walks. Four kinds of page are tried: read/write, read-only, write-only, and pages missing at either level. This shows apart the two fault kinds, the one-read and two-read walk endings, and whether a faulted leaf gets installed. A sweep over nine pages after a flush shows which slot the replacement takes. Reads and writes on clean entries show when the dirty bit changes.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  // table word flag positions
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_D = 3;
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lu_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_r_o,
  output logic             hit_w_o,
  output logic             hit_d_o,
  input  logic             set_dirty_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_r_i,
  input  logic             fill_w_i,
  input  logic             fill_d_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q, r_q, w_q, d_q, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, hit_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = valid_q[g] && (tag_q[g] == lu_vpn_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit_o     = |match;
  assign hit_ppn_o = ppn_q[hit_idx];
  assign hit_r_o   = r_q[hit_idx];
  assign hit_w_o   = w_q[hit_idx];
  assign hit_d_o   = d_q[hit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      r_q     <= '0;
      w_q     <= '0;
      d_q     <= '0;
      rr_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;  // flush wins over a same-cycle install
    end else begin
      if (set_dirty_i) d_q[hit_idx] <= 1'b1;
      if (fill_i) begin
        valid_q[rr_q] <= 1'b1;
        tag_q[rr_q]   <= fill_vpn_i;
        ppn_q[rr_q]   <= fill_ppn_i;
        r_q[rr_q]     <= fill_r_i;
        w_q[rr_q]     <= fill_w_i;
        d_q[rr_q]     <= fill_d_i;
        rr_q          <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  assert_flush_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
endmodule

// File: rtl/tlbw_walk.sv
module tlbw_walk import tlbw_pkg::*; #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [L1_W+L2_W-1:0]  vpn_i,
  input  logic [PA_W-OFF_W-1:0] ptb_ppn_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  pf_o,
  output logic [PA_W-OFF_W-1:0] pte_ppn_o,
  output logic                  pte_r_o,
  output logic                  pte_w_o,
  output logic                  pte_d_o,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [PA_W-1:0]       mem_req_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [PA_W-1:0]       mem_rsp_data_i
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int VPN_W = L1_W + L2_W;

  typedef enum logic [2:0] {W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT} wstate_e;

  wstate_e          st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] base_q;
  logic             present;
  logic             unused_pte_bits;

  assign present         = mem_rsp_data_i[PTE_V];
  assign unused_pte_bits = ^mem_rsp_data_i[OFF_W-1:PTE_D+1];

  always_comb begin
    if (st_q == W_L2_REQ)
      mem_req_addr_o = {base_q, {OFF_W{1'b0}}} + (PA_W'(vpn_q[L2_W-1:0]) << 2);
    else
      mem_req_addr_o = {base_q, {OFF_W{1'b0}}} + (PA_W'(vpn_q[VPN_W-1:L2_W]) << 2);
  end

  assign mem_req_valid_o = (st_q == W_L1_REQ) || (st_q == W_L2_REQ);
  assign busy_o          = (st_q != W_IDLE);
  assign done_o          = mem_rsp_valid_i &&
                           ((st_q == W_L2_WAIT) || ((st_q == W_L1_WAIT) && !present));
  assign pf_o            = !present;
  assign pte_ppn_o       = mem_rsp_data_i[PA_W-1:OFF_W];
  assign pte_r_o         = mem_rsp_data_i[PTE_R];
  assign pte_w_o         = mem_rsp_data_i[PTE_W];
  assign pte_d_o         = mem_rsp_data_i[PTE_D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      vpn_q  <= '0;
      base_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          vpn_q  <= vpn_i;
          base_q <= ptb_ppn_i;
          st_q   <= W_L1_REQ;
        end
        W_L1_REQ:  if (mem_req_ready_i) st_q <= W_L1_WAIT;
        W_L1_WAIT: if (mem_rsp_valid_i) begin
          if (present) begin
            base_q <= mem_rsp_data_i[PA_W-1:OFF_W];
            st_q   <= W_L2_REQ;
          end else st_q <= W_IDLE;
        end
        W_L2_REQ:  if (mem_req_ready_i) st_q <= W_L2_WAIT;
        W_L2_WAIT: if (mem_rsp_valid_i) st_q <= W_IDLE;
        default:   st_q <= W_IDLE;
      endcase
    end
  end

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
endmodule

// File: rtl/tlbw_perm.sv
module tlbw_perm (
  input  logic write_i,
  input  logic rd_ok_i,
  input  logic wr_ok_i,
  output logic allow_o
);
  assign allow_o = write_i ? wr_ok_i : rd_ok_i;
endmodule

// File: rtl/tlb_ptw.sv
module tlb_ptw import tlbw_pkg::*; #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int L1_W    = 10,
  parameter int ENTRIES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [PA_W-1:0] ptbr_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_va_i,
  input  logic            req_write_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic [1:0]      rsp_fault_o,
  output logic            rsp_dirty_o,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [PA_W-1:0] mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [PA_W-1:0] mem_rsp_data_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int L2_W  = VPN_W - L1_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic             req_fire, hit, hit_r, hit_w, hit_d, hit_allow, fill_allow;
  logic [PPN_W-1:0] hit_ppn, walk_ppn;
  logic             walk_busy, walk_done, walk_pf, walk_r, walk_w, walk_d;
  logic             walk_start, set_dirty, fill_en, fill_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             unused_ptbr;

  assign unused_ptbr = ^ptbr_i[OFF_W-1:0];
  assign req_ready_o = !walk_busy && !flush_i;
  assign req_fire    = req_valid_i && req_ready_o;
  assign walk_start  = req_fire && !hit;
  assign set_dirty   = req_fire && hit && req_write_i && hit_allow && !hit_d;
  assign fill_en     = walk_done && !walk_pf;
  assign fill_d      = walk_d || (wr_q && fill_allow);

  tlbw_cam #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) u_cam (
    .clk_i, .rst_ni, .flush_i,
    .lu_vpn_i   (req_va_i[VA_W-1:OFF_W]),
    .hit_o      (hit),
    .hit_ppn_o  (hit_ppn),
    .hit_r_o    (hit_r),
    .hit_w_o    (hit_w),
    .hit_d_o    (hit_d),
    .set_dirty_i(set_dirty),
    .fill_i     (fill_en),
    .fill_vpn_i (vpn_q),
    .fill_ppn_i (walk_ppn),
    .fill_r_i   (walk_r),
    .fill_w_i   (walk_w),
    .fill_d_i   (fill_d)
  );

  tlbw_walk #(.PA_W(PA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i        (walk_start),
    .vpn_i          (req_va_i[VA_W-1:OFF_W]),
    .ptb_ppn_i      (ptbr_i[PA_W-1:OFF_W]),
    .busy_o         (walk_busy),
    .done_o         (walk_done),
    .pf_o           (walk_pf),
    .pte_ppn_o      (walk_ppn),
    .pte_r_o        (walk_r),
    .pte_w_o        (walk_w),
    .pte_d_o        (walk_d),
    .mem_req_valid_o,
    .mem_req_ready_i,
    .mem_req_addr_o,
    .mem_rsp_valid_i,
    .mem_rsp_data_i
  );

  tlbw_perm u_perm_hit  (.write_i(req_write_i), .rd_ok_i(hit_r),  .wr_ok_i(hit_w),  .allow_o(hit_allow));
  tlbw_perm u_perm_fill (.write_i(wr_q),        .rd_ok_i(walk_r), .wr_ok_i(walk_w), .allow_o(fill_allow));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q <= '0;
      off_q <= '0;
      wr_q  <= 1'b0;
    end else if (walk_start) begin
      vpn_q <= req_va_i[VA_W-1:OFF_W];
      off_q <= req_va_i[OFF_W-1:0];
      wr_q  <= req_write_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= FLT_NONE;
      rsp_dirty_o <= 1'b0;
    end else if (req_fire && hit) begin
      rsp_valid_o <= 1'b1;
      rsp_pa_o    <= hit_allow ? {hit_ppn, req_va_i[OFF_W-1:0]} : '0;
      rsp_fault_o <= hit_allow ? FLT_NONE : FLT_PROT;
      rsp_dirty_o <= hit_d || set_dirty;
    end else if (walk_done) begin
      rsp_valid_o <= 1'b1;
      if (walk_pf) begin
        rsp_pa_o    <= '0;
        rsp_fault_o <= FLT_PAGE;
        rsp_dirty_o <= 1'b0;
      end else begin
        rsp_pa_o    <= fill_allow ? {walk_ppn, off_q} : '0;
        rsp_fault_o <= fill_allow ? FLT_NONE : FLT_PROT;
        rsp_dirty_o <= fill_d;
      end
    end else begin
      rsp_valid_o <= 1'b0;
    end
  end

  assert_hit_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && hit) |=> rsp_valid_o);

  assert_fault_zero_pa_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_pa_o == '0));

  assert_no_accept_in_walk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);
endmodule

// File: tb/sim_tlb_ptw.sv
module sim_tlb_ptw;
  localparam logic [31:0] PTB = 32'h0010_0000;
  localparam logic [3:0]  F_RW = 4'b0111, F_RO = 4'b0011, F_WO = 4'b0101;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid, req_write, mem_ready, mem_rvalid;
  logic [31:0] ptbr, req_va, mem_rdata;
  logic        req_ready, rsp_valid, rsp_dirty, mem_valid;
  logic [31:0] rsp_pa, mem_addr;
  logic [1:0]  rsp_fault;

  always #5 clk = ~clk;

  tlb_ptw u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .ptbr_i(ptbr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .rsp_dirty_o(rsp_dirty),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready), .mem_req_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rvalid), .mem_rsp_data_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int reads = 0;
  logic [31:0] addr_log [0:1];
  logic [31:0] mem [int unsigned];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: one stall cycle before ready, two cycles of latency
  initial begin
    logic        seen, pend;
    logic [31:0] paddr;
    int          lat;
    seen = 0; pend = 0; paddr = '0; lat = 0;
    mem_ready = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (mem_ready) begin
        mem_ready = 0; pend = 1; lat = 1;
      end else if (pend) begin
        if (lat == 0) begin
          mem_rvalid = 1;
          mem_rdata  = mem.exists(paddr) ? mem[paddr] : 32'h0;
          pend = 0;
        end else lat--;
      end else if (mem_valid) begin
        if (seen) begin
          mem_ready = 1; seen = 0; paddr = mem_addr;
          addr_log[reads % 2] = mem_addr;
          reads++;
        end else seen = 1;
      end
    end
  end

  function automatic logic [31:0] l2_base(input logic [9:0] v1);
    return 32'h0020_0000 + ({22'h0, v1} << 12);
  endfunction

  task automatic map_page(input logic [9:0] v1, input logic [9:0] v0,
                          input logic [19:0] ppn, input logic [3:0] fl);
    mem[PTB + {20'h0, v1, 2'b00}]      = l2_base(v1) | 32'h1;
    mem[l2_base(v1) + {20'h0, v0, 2'b00}] = {ppn, 8'h00, fl};
  endtask

  // issue one request at a negedge, return the answer and statistics
  task automatic xlate(input logic [31:0] va, input logic wr,
                       output logic [31:0] pa, output logic [1:0] f, output logic d,
                       output int lat, output int nrd, output logic rdy_after);
    int r0;
    r0 = reads;
    req_valid = 1; req_va = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    rdy_after = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
    pa = rsp_pa; f = rsp_fault; d = rsp_dirty;
    nrd = reads - r0;
    @(negedge clk);
  endtask

  logic [31:0] pa; logic [1:0] f; logic d, ra; int lat, nrd;

  task automatic t_reset;
    chk("R11 req_ready in reset", {31'h0, req_ready}, 32'h1);
    chk("R11 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    chk("R11 mem_req_valid in reset", {31'h0, mem_valid}, 32'h0);
  endtask

  task automatic t_miss_then_hit;
    xlate(32'h0040_1ABC, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R3 miss reads", nrd, 2);
    chk("R3 first-level address", addr_log[0], 32'h0010_0004);
    chk("R3 second-level address", addr_log[1], 32'h0020_1004);
    chk("R1 miss pa", pa, 32'h1234_5ABC);
    chk("R6 miss fault none", {30'h0, f}, 32'h0);
    chk("R10 ready low during walk", {31'h0, ra}, 32'h0);
    xlate(32'h0040_1004, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R2 hit latency", lat, 1);
    chk("R2 hit reads", nrd, 0);
    chk("R2 ready stays high on hit", {31'h0, ra}, 32'h1);
    chk("R1 hit pa offset passthrough", pa, 32'h1234_5004);
    chk("R8 clean read dirty", {31'h0, d}, 32'h0);
  endtask

  task automatic t_dirty;
    xlate(32'h0040_1010, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R8 write hit sets dirty", {31'h0, d}, 32'h1);
    chk("R8 write hit pa", pa, 32'h1234_5010);
    xlate(32'h0040_1020, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R8 dirty persists", {31'h0, d}, 32'h1);
  endtask

  task automatic t_protect;
    xlate(32'h0040_2008, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R6 write to read-only fault", {30'h0, f}, 32'h2);
    chk("R6 fault pa zero", pa, 32'h0);
    chk("R6 walk reads", nrd, 2);
    xlate(32'h0040_2008, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R6 faulted leaf installed reads", nrd, 0);
    chk("R6 read-only read ok", pa, 32'h0AAAA_008);
    xlate(32'h0040_200C, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R6 write hit denied", {30'h0, f}, 32'h2);
    xlate(32'h0040_200C, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R8 denied write keeps clean", {31'h0, d}, 32'h0);
    xlate(32'h0040_4100, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R6 read of write-only fault", {30'h0, f}, 32'h2);
    xlate(32'h0040_4100, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R6 write-only write ok", pa, 32'h0BBBB_100);
    chk("R8 write-only write dirty", {31'h0, d}, 32'h1);
  endtask

  task automatic t_page_fault;
    xlate(32'h0040_3000, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R5 leaf not present fault", {30'h0, f}, 32'h1);
    chk("R5 leaf fault reads", nrd, 2);
    chk("R5 fault pa zero", pa, 32'h0);
    xlate(32'h0040_3000, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R5 retry walks again", nrd, 2);
    xlate(32'h00C0_0000, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R5 first-level fault", {30'h0, f}, 32'h1);
    chk("R5 first-level fault one read", nrd, 1);
  endtask

  task automatic t_flush;
    flush = 1;
    #1;
    chk("R9 ready low during flush", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    flush = 0;
    xlate(32'h0040_1000, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R9 cached page walks after flush", nrd, 2);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 8; k++)
      xlate(32'h0080_0000 + k * 32'h1000, 1'b0, pa, f, d, lat, nrd, ra);
    for (int k = 0; k < 8; k++) begin
      xlate(32'h0080_0000 + k * 32'h1000, 1'b0, pa, f, d, lat, nrd, ra);
      chk("R7 eight pages all resident", nrd, 0);
    end
    xlate(32'h0080_8000, 1'b1, pa, f, d, lat, nrd, ra);
    chk("R7 ninth page walks", nrd, 2);
    chk("R8 write miss installs dirty", {31'h0, d}, 32'h1);
    for (int k = 1; k < 8; k++) begin
      xlate(32'h0080_0000 + k * 32'h1000, 1'b0, pa, f, d, lat, nrd, ra);
      chk("R7 survivors still hit", nrd, 0);
    end
    xlate(32'h0080_0000, 1'b0, pa, f, d, lat, nrd, ra);
    chk("R7 oldest evicted", nrd, 2);
    chk("R7 refilled pa", pa, 32'h5000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; flush = 0; req_valid = 0; req_write = 0; req_va = '0; ptbr = PTB;
    map_page(10'd1, 10'd1, 20'h12345, F_RW);
    map_page(10'd1, 10'd2, 20'h0AAAA, F_RO);
    map_page(10'd1, 10'd4, 20'h0BBBB, F_WO);
    for (int k = 0; k < 9; k++) map_page(10'd2, 10'(k), 20'h50000 + 20'(k), F_RW);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_miss_then_hit();
    t_dirty();
    t_protect();
    t_page_fault();
    t_flush();
    t_round_robin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule